// File: doc/BRIEF.md
# Main Clock Frequency Meter

This block estimates how fast the main clock runs by using the slow clock as a time base. The slow-clock side opens a measurement window that lasts a fixed number of slow-clock cycles. While the window is open, a counter in the main-clock domain counts rising edges of the main clock. After the window closes and the counter has settled, the slow-clock side copies the count into a result field and raises a ready flag. Software polls the ready flag and then reads the result with a further access.

The window edges cross into the main-clock domain through two-flop synchronisers. The counter is cleared before each window by an asynchronous clear that is released synchronously. A stopped main clock therefore still leaves a count of zero. A result of zero means that no main oscillator is running. Picking a fallback clock source from that result is a software decision and is outside this block. A change on the source-select level restarts the measurement. The ready flag then stays low until the new result is loaded. The result field changes only at the end of a measurement, so a read never sees a partial count.

The result and ready flag are plain status outputs in the slow-clock domain. No stream carries data in or out of this block, so there is no handshake and no back-pressure. The main clock is assumed to run at least as fast as the slow clock.

Top module: `mfm_meter`

## Requirements
- R1: While reset is asserted, freq_ready is 0 and freq_count is 0. After reset is released, a first measurement starts by itself, and freq_ready rises on the 24th slow-clock rising edge after release (default parameters).
- R2: The window lasts exactly WIN_CYC slow-clock cycles (default 16). The loaded freq_count equals the number of main-clock rising edges in that time, within one count.
- R3: A change of the src_sel level is sampled on a slow-clock rising edge. On that same edge freq_ready goes to 0 and a new measurement starts.
- R4: If the main clock is stopped during a measurement, the result is 0, even when the previous result was nonzero.
- R5: freq_ready rises on the CLR_CYC+WIN_CYC+SET_CYC-th (default 24th) slow-clock rising edge after the edge that sampled the src_sel change. freq_count is loaded on that same edge.
- R6: The count saturates at all ones, 2^CNT_W-1, and never wraps to a small value.
- R7: While a measurement is in progress, freq_count keeps the previous result. It changes only on the edge where freq_ready rises.
- R8: If a src_sel change is sampled on the same edge that would load a result, the restart wins. freq_ready stays 0, freq_count keeps its old value, and the new result arrives 24 edges later.
- R9: While src_sel is steady after a result, freq_ready stays 1 and freq_count stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slow_clk | input | 1 | Slow reference clock; the time base of the window and the status outputs |
| main_clk | input | 1 | Main clock under measurement; may be stopped |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 1 | Main clock source select level (slow domain); any change restarts the measurement |
| freq_ready | output | 1 | Set when freq_count holds a finished measurement |
| freq_count | output | CNT_W | Main-clock edges counted in the last window; 0 means no oscillator |

## Verification
Loading a result and restarting on a source change are two functions that can fall on the same slow-clock edge. The bench provokes this by toggling src_sel on the falling edge just before the edge that would load a result. It then checks that freq_ready stays low and that freq_count still holds the earlier value. Finally it checks that the next result, taken at a different main-clock rate, arrives one full measurement later with the value for the new rate.

// File: rtl/mfm_pkg.sv
package mfm_pkg;

  typedef enum logic [1:0] {
    ST_CLEAR  = 2'd0,
    ST_WIN    = 2'd1,
    ST_SETTLE = 2'd2,
    ST_DONE   = 2'd3
  } mfm_state_e;

  function automatic int mfm_max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/mfm_sync2.sv
module mfm_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr <= '0;
    else         sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];

endmodule

// File: rtl/mfm_edge_cnt.sv
module mfm_edge_cnt #(
  parameter int CNT_W     = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic             main_clk,
  input  logic             clr_n,
  input  logic             win_en,
  output logic [CNT_W-1:0] cnt,
  output logic             main_rst_n
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic en_s;

  // Clear asserts at once, even with no main clock; release is synchronous.
  mfm_sync2 #(.STAGES(SYNC_STGS)) u_rst_sync (
    .clk    (main_clk),
    .arst_n (clr_n),
    .d      (1'b1),
    .q      (main_rst_n)
  );

  mfm_sync2 #(.STAGES(SYNC_STGS)) u_win_sync (
    .clk    (main_clk),
    .arst_n (main_rst_n),
    .d      (win_en),
    .q      (en_s)
  );

  always_ff @(posedge main_clk or negedge main_rst_n) begin
    if (!main_rst_n)                  cnt <= '0;
    else if (en_s && (cnt != CNT_MAX)) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/mfm_seq.sv
module mfm_seq
  import mfm_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int CLR_CYC = 4,
  parameter int WIN_CYC = 16,
  parameter int SET_CYC = 4
) (
  input  logic             slow_clk,
  input  logic             rst_n,
  input  logic             src_sel,
  input  logic [CNT_W-1:0] cnt_main,
  output logic             clr_req,
  output logic             win_en,
  output logic             restart,
  output logic             ready,
  output logic [CNT_W-1:0] result
);

  localparam int TMAX  = mfm_max3(CLR_CYC, WIN_CYC, SET_CYC);
  localparam int TMR_W = $clog2(TMAX + 1);
  localparam logic [TMR_W-1:0] T_CLR = TMR_W'(CLR_CYC - 1);
  localparam logic [TMR_W-1:0] T_WIN = TMR_W'(WIN_CYC - 1);
  localparam logic [TMR_W-1:0] T_SET = TMR_W'(SET_CYC - 1);
  localparam logic [TMR_W-1:0] T_ONE = TMR_W'(1);

  mfm_state_e       state;
  logic [TMR_W-1:0] tmr;
  logic             src_q;

  assign restart = (src_sel != src_q);

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_CLEAR;
      tmr     <= T_CLR;
      src_q   <= 1'b0;
      clr_req <= 1'b1;
      win_en  <= 1'b0;
      ready   <= 1'b0;
      result  <= '0;
    end else begin
      src_q <= src_sel;
      if (restart) begin
        // Restart has priority over every phase, including the load.
        state   <= ST_CLEAR;
        tmr     <= T_CLR;
        clr_req <= 1'b1;
        win_en  <= 1'b0;
        ready   <= 1'b0;
      end else begin
        unique case (state)
          ST_CLEAR: begin
            if (tmr == T_ONE) clr_req <= 1'b0;
            if (tmr == '0) begin
              state  <= ST_WIN;
              tmr    <= T_WIN;
              win_en <= 1'b1;
            end else begin
              tmr <= tmr - 1'b1;
            end
          end
          ST_WIN: begin
            if (tmr == '0) begin
              state  <= ST_SETTLE;
              tmr    <= T_SET;
              win_en <= 1'b0;
            end else begin
              tmr <= tmr - 1'b1;
            end
          end
          ST_SETTLE: begin
            if (tmr == '0) begin
              state  <= ST_DONE;
              ready  <= 1'b1;
              result <= cnt_main;
            end else begin
              tmr <= tmr - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/mfm_meter.sv
module mfm_meter #(
  parameter int CNT_W     = 16,
  parameter int CLR_CYC   = 4,
  parameter int WIN_CYC   = 16,
  parameter int SET_CYC   = 4,
  parameter int SYNC_STGS = 2
) (
  input  logic             slow_clk,
  input  logic             main_clk,
  input  logic             rst_n,
  input  logic             src_sel,
  output logic             freq_ready,
  output logic [CNT_W-1:0] freq_count
);

  logic             clr_req_s;
  logic             win_en_s;
  logic             restart_s;
  logic             main_clr_n;
  logic             main_rst_n_s;
  logic [CNT_W-1:0] cnt_main_s;

  assign main_clr_n = rst_n & ~clr_req_s;

  mfm_seq #(
    .CNT_W   (CNT_W),
    .CLR_CYC (CLR_CYC),
    .WIN_CYC (WIN_CYC),
    .SET_CYC (SET_CYC)
  ) u_seq (
    .slow_clk (slow_clk),
    .rst_n    (rst_n),
    .src_sel  (src_sel),
    .cnt_main (cnt_main_s),
    .clr_req  (clr_req_s),
    .win_en   (win_en_s),
    .restart  (restart_s),
    .ready    (freq_ready),
    .result   (freq_count)
  );

  mfm_edge_cnt #(
    .CNT_W     (CNT_W),
    .SYNC_STGS (SYNC_STGS)
  ) u_cnt (
    .main_clk   (main_clk),
    .clr_n      (main_clr_n),
    .win_en     (win_en_s),
    .cnt        (cnt_main_s),
    .main_rst_n (main_rst_n_s)
  );

endmodule

// File: rtl/mfm_meter_chk.sv
module mfm_meter_chk #(
  parameter int CNT_W   = 16,
  parameter int WIN_CYC = 16
) (
  input logic             slow_clk,
  input logic             main_clk,
  input logic             rst_n,
  input logic             src_sel,
  input logic             freq_ready,
  input logic [CNT_W-1:0] freq_count,
  input logic             win_en,
  input logic             restart,
  input logic [CNT_W-1:0] cnt_main,
  input logic             main_rst_n
);

  localparam int RUN_W = $clog2(WIN_CYC + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [RUN_W-1:0] win_run;

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n)      win_run <= '0;
    else if (win_en) win_run <= win_run + 1'b1;
    else             win_run <= '0;
  end

  // R2: an uninterrupted window is exactly WIN_CYC slow cycles long
  p_window_len_r2: assert property (@(posedge slow_clk) disable iff (!rst_n)
    ($fell(win_en) && !$past(restart)) |-> (win_run == RUN_W'(WIN_CYC)));

  // R3: a sampled source change drops the ready flag
  p_ready_drop_r3: assert property (@(posedge slow_clk) disable iff (!rst_n)
    (src_sel != $past(src_sel)) |=> !freq_ready);

  // R6: the main-domain counter holds at all ones
  p_no_overflow_r6: assert property (@(posedge main_clk) disable iff (!main_rst_n)
    (cnt_main == CNT_MAX) |=> (cnt_main == CNT_MAX));

  // R7: the result moves only when ready rises
  p_result_atomic_r7: assert property (@(posedge slow_clk) disable iff (!rst_n)
    (freq_count != $past(freq_count)) |-> $rose(freq_ready));

  // R9: with a steady source, ready stays set
  p_ready_hold_r9: assert property (@(posedge slow_clk) disable iff (!rst_n)
    (freq_ready && (src_sel == $past(src_sel))) |=> freq_ready);

endmodule

bind mfm_meter mfm_meter_chk #(
  .CNT_W   (CNT_W),
  .WIN_CYC (WIN_CYC)
) u_chk (
  .slow_clk   (slow_clk),
  .main_clk   (main_clk),
  .rst_n      (rst_n),
  .src_sel    (src_sel),
  .freq_ready (freq_ready),
  .freq_count (freq_count),
  .win_en     (win_en_s),
  .restart    (restart_s),
  .cnt_main   (cnt_main_s),
  .main_rst_n (main_rst_n_s)
);

// File: tb/mfm_meter_bench.sv
`timescale 1ns/1ps
module mfm_meter_bench;

  localparam int SLOW_PERIOD = 320;
  localparam int CNT_W       = 12;
  localparam int LAT         = 24;
  localparam int SAT_VAL     = (1 << CNT_W) - 1;
  localparam int WD_NS       = 2_000_000;
  localparam int VEC_N       = 6;
  // {main half period in ns (0 = stopped), expected count}
  localparam int VEC [VEC_N][2] = '{
    '{10, 256}, '{5, 512}, '{20, 128}, '{0, 0}, '{4, 640}, '{16, 160}
  };

  logic             slow_clk = 1'b0;
  logic             main_clk = 1'b0;
  logic             rst_n    = 1'b0;
  logic             src_sel  = 1'b0;
  logic             freq_ready;
  logic [CNT_W-1:0] freq_count;

  int slow_half = SLOW_PERIOD / 2;
  int main_half = 10;
  int checks    = 0;
  int errors    = 0;

  mfm_meter #(.CNT_W(CNT_W)) u_mfm_meter (
    .slow_clk   (slow_clk),
    .main_clk   (main_clk),
    .rst_n      (rst_n),
    .src_sel    (src_sel),
    .freq_ready (freq_ready),
    .freq_count (freq_count)
  );

  always #(slow_half) slow_clk = ~slow_clk;

  initial begin
    #3;
    forever begin
      if (main_half > 0) begin
        #(main_half) main_clk = ~main_clk;
      end else begin
        main_clk = 1'b0;
        #1;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp, input int tol);
    int d;
    checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic negs(input int n);
    for (int i = 0; i < n; i++) @(negedge slow_clk);
  endtask

  // Toggle src_sel, then check ready, hold of old result, latency and value.
  task automatic measure(input int half, input int exp, input int tol, input string req);
    int prev;
    prev = int'(freq_count);
    main_half = half;
    src_sel = ~src_sel;
    negs(1);
    check("R3 ready clears on source change", int'(freq_ready), 0, 0);
    negs(11);
    check("R7 result held mid-measurement", int'(freq_count), prev, 0);
    negs(LAT - 12);
    check("R5 ready still low before load edge", int'(freq_ready), 0, 0);
    negs(1);
    check("R5 ready set on load edge", int'(freq_ready), 1, 0);
    check(req, int'(freq_count), exp, tol);
  endtask

  initial begin
    #(WD_NS);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int held;
    negs(5);
    check("R1 reset ready", int'(freq_ready), 0, 0);
    check("R1 reset count", int'(freq_count), 0, 0);
    rst_n = 1'b1;
    negs(LAT - 1);
    check("R1 first measurement not yet ready", int'(freq_ready), 0, 0);
    negs(1);
    check("R1 first measurement ready", int'(freq_ready), 1, 0);
    check("R2 first measurement count", int'(freq_count), 256, 1);

    for (int v = 0; v < VEC_N; v++) begin
      if (VEC[v][0] == 0) measure(0, 0, 0, "R4 stopped main clock gives zero");
      else                measure(VEC[v][0], VEC[v][1], 1, "R2 count over window");
    end

    held = int'(freq_count);
    negs(40);
    check("R9 ready held with steady source", int'(freq_ready), 1, 0);
    check("R9 count held with steady source", int'(freq_count), held, 0);

    // R8: restart sampled on the same edge that would load the result.
    main_half = 5;
    src_sel = ~src_sel;
    negs(LAT);
    check("R8 ready low before collision", int'(freq_ready), 0, 0);
    src_sel = ~src_sel;
    negs(1);
    check("R8 restart wins, ready low", int'(freq_ready), 0, 0);
    check("R8 restart wins, count kept", int'(freq_count), held, 0);
    negs(LAT - 1);
    check("R8 new result not yet ready", int'(freq_ready), 0, 0);
    negs(1);
    check("R8 new result ready", int'(freq_ready), 1, 0);
    check("R8 new result value", int'(freq_count), 512, 1);

    // R6: ratio 320 gives 5120 edges, above the 12-bit ceiling.
    slow_half = 640;
    negs(2);
    measure(2, SAT_VAL, 0, "R6 count saturates at all ones");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule